// File: doc/BRIEF.md
# Converter-Side Serial Port

This block is the digital face of a sampling converter: the logic that a host controller talks to over a three-wire serial link. The host raises a conversion strobe to start a conversion and then toggles a serial clock. The block counts the serial clock edges of each conversion frame and shifts out a parallel sample, most significant bit first, on a single data line. The sample arrives on an input port, so the block can be tested against a host controller without any analog front end.

A strobe that arrives while a frame is still running does not start a conversion. Several strobes in a row with no serial clock edge between them put the block into a low-power state. The block reports that state on a status output, and any serial clock edge ends it. Both inputs are sampled on a fast system clock, and a rising edge is detected as a high level whose previous sampled value was low.

Top module: `conv_serial_port`

## Requirements
- R1: Take a strobe rising edge while the block is neither busy nor asleep. The strobe is accepted: `busy` is high from the next system clock, and the value on `sampleIn` in that cycle is the word later shifted out.
- R2: A strobe rising edge that arrives while `busy` is high has no effect on the frame. `busy` stays high until the 16th serial clock rising edge after the accepted strobe and is low from the cycle after that edge.
- R3: `sdo` changes only on serial clock rising edges. After the 3rd serial clock rising edge of a frame it carries sample bit 11. After edges 4 to 14 it carries bits 10 down to 0, in that order.
- R4: `sdo` is 0 after edges 15 and 16, whenever `busy` is low, and while `asleep` is high.
- R5: A 4th strobe rising edge with no serial clock rising edge since the 1st sets `asleep` and clears `busy`.
- R6: A serial clock rising edge restarts the strobe run count. Three strobes, one serial clock edge and then three more strobes leave `asleep` low.
- R7: Any serial clock rising edge while asleep clears `asleep` from the next cycle.
- R8: A strobe rising edge while asleep does not start a conversion. After the wake, `busy` is low and `sdo` is 0.
- R9: A strobe edge and a serial clock edge may fall in the same system cycle. The clock edge is handled first: it counts, it wakes the block and it restarts the run count. The strobe is then judged against the state held before that cycle, and it counts as the 1st strobe of a new run.
- R10: After reset, `busy`, `asleep` and `sdo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| convIn | input | 1 | Conversion strobe from the host |
| sckIn | input | 1 | Serial clock from the host |
| sampleIn | input | 12 | Parallel sample captured at an accepted strobe |
| sdo | output | 1 | Serial data line |
| busy | output | 1 | High while a conversion frame is in progress |
| asleep | output | 1 | High while in the low-power state |

## Verification
A strobe edge and a serial clock edge can be detected in the same system cycle. In that cycle, frame counting, wake-up and the strobe run count all act at once. The bench provokes this by raising both inputs on one falling clock edge, both while a frame is running and while asleep. The strobe must then count as the first of a fresh run, so three more strobes put the block to sleep. The strobe must also be rejected against the busy state held before the cycle. A behavioural model judges every cycle, and explicit checks confirm the resulting sleep and busy values.

// File: rtl/sport_pkg.sv
package sport_pkg;
  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic load;    // capture the sample, clear the line
    logic outBit;  // present the next bit, MSB first
    logic zero;    // drive the line low
  } dpStrobe_t;
endpackage

// File: rtl/sport_dp.sv
module sport_dp
  import sport_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdo
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= sampleIn;
      sdo      <= 1'b0;
    end else if (strb.outBit) begin
      sdo      <= shiftReg[DATA_W-1];
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end else if (strb.zero) begin
      sdo      <= 1'b0;
    end
  end

  // R1: control never issues two datapath actions in one cycle
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.outBit, strb.zero}));
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME   = 16,
  parameter int LEAD    = 3,
  parameter int SLEEP_N = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      convIn,
  input  logic      sckIn,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      asleep
);
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int SLP_W = $clog2(SLEEP_N + 1);
  localparam logic [CNT_W-1:0] FIRST_SLOT = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] LAST_SLOT  = CNT_W'(LEAD + DATA_W - 1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME);
  localparam logic [SLP_W-1:0] SLEEP_LAST = SLP_W'(SLEEP_N - 1);

  logic convPrev, sckPrev, convRise, sckRise;
  logic [CNT_W-1:0] edgeCnt, cntNext, cntInc;
  logic [SLP_W-1:0] slpCnt, slpNext;
  logic busyNext, asleepNext;

  assign convRise = convIn & ~convPrev;
  assign sckRise  = sckIn & ~sckPrev;
  assign cntInc   = edgeCnt + 1'b1;

  always_comb begin
    busyNext   = busy;
    asleepNext = asleep;
    cntNext    = edgeCnt;
    slpNext    = slpCnt;
    strb       = '0;
    // serial clock edge first: count, wake, restart the strobe run
    if (sckRise) begin
      asleepNext = 1'b0;
      slpNext    = '0;
      if (busy) begin
        cntNext = cntInc;
        if (cntInc >= FIRST_SLOT && cntInc <= LAST_SLOT) strb.outBit = 1'b1;
        else                                             strb.zero   = 1'b1;
        if (cntInc == FRAME_END) busyNext = 1'b0;
      end
    end
    // strobe edge, judged on state held before this cycle
    if (convRise && !(asleep && !sckRise)) begin
      if (!busy && !asleep) begin
        busyNext = 1'b1;
        cntNext  = '0;
        strb     = '0;
        strb.load = 1'b1;
      end
      if (slpNext == SLEEP_LAST) begin
        asleepNext = 1'b1;
        busyNext   = 1'b0;
        slpNext    = '0;
        strb       = '0;
        strb.zero  = 1'b1;
      end else begin
        slpNext = slpNext + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convPrev <= 1'b0;
      sckPrev  <= 1'b0;
      edgeCnt  <= '0;
      slpCnt   <= '0;
      busy     <= 1'b0;
      asleep   <= 1'b0;
    end else begin
      convPrev <= convIn;
      sckPrev  <= sckIn;
      edgeCnt  <= cntNext;
      slpCnt   <= slpNext;
      busy     <= busyNext;
      asleep   <= asleepNext;
    end
  end

  // R2: the frame counter never runs past the frame length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= FRAME_END);
  // R5: no frame survives entry into sleep
  p_sleep_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> !busy);
  // R7: a serial clock edge always ends sleep
  p_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && sckRise) |=> !asleep);
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import sport_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME   = 16,
  parameter int LEAD    = 3,
  parameter int SLEEP_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convIn,
  input  logic              sckIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdo,
  output logic              busy,
  output logic              asleep
);
  dpStrobe_t strb;

  sport_ctrl #(
    .DATA_W(DATA_W), .FRAME(FRAME), .LEAD(LEAD), .SLEEP_N(SLEEP_N)
  ) ctrl (
    .clk(clk), .rstN(rstN), .convIn(convIn), .sckIn(sckIn),
    .strb(strb), .busy(busy), .asleep(asleep)
  );

  sport_dp #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn), .sdo(sdo)
  );

  // R4: the data line is quiet whenever no frame runs
  p_sdo_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdo);
endmodule

// File: tb/conv_serial_port_test.sv
module conv_serial_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convIn = 1'b0;
  logic sckIn = 1'b0;
  logic [11:0] sampleIn = '0;
  logic sdo, busy, asleep;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  conv_serial_port uut (
    .clk(clk), .rstN(rstN), .convIn(convIn), .sckIn(sckIn),
    .sampleIn(sampleIn), .sdo(sdo), .busy(busy), .asleep(asleep)
  );

  // behavioural reference model
  int mBusy, mSleep, mSdo, mCnt, mRun, mSample;
  int mConvPrev, mSckPrev;
  always @(posedge clk or negedge rstN) begin
    int cr, sr, wasBusy, wasSleep;
    if (!rstN) begin
      mBusy = 0; mSleep = 0; mSdo = 0; mCnt = 0; mRun = 0; mSample = 0;
      mConvPrev = 0; mSckPrev = 0;
    end else begin
      cr = (convIn && !mConvPrev) ? 1 : 0;
      sr = (sckIn && !mSckPrev) ? 1 : 0;
      mConvPrev = int'(convIn);
      mSckPrev = int'(sckIn);
      wasBusy = mBusy;
      wasSleep = mSleep;
      if (sr != 0) begin
        mSleep = 0;
        mRun = 0;
        if (wasBusy != 0) begin
          mCnt++;
          if (mCnt >= 3 && mCnt <= 14) mSdo = (mSample >> (14 - mCnt)) & 1;
          else mSdo = 0;
          if (mCnt == 16) mBusy = 0;
        end
      end
      if (cr != 0 && !(wasSleep != 0 && sr == 0)) begin
        if (wasBusy == 0 && wasSleep == 0) begin
          mBusy = 1; mCnt = 0; mSample = int'(sampleIn); mSdo = 0;
        end
        mRun++;
        if (mRun == 4) begin
          mSleep = 1; mRun = 0; mBusy = 0; mSdo = 0;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R1 R2 busy", int'(busy), mBusy);
      check("R5 R7 asleep", int'(asleep), mSleep);
      check("R3 R4 sdo", int'(sdo), mSdo);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic c, input logic s);
    @(negedge clk);
    convIn = c; sckIn = s;
    @(negedge clk);
    convIn = 1'b0; sckIn = 1'b0;
  endtask

  // one serial clock pulse; returns sdo just after its rising edge
  task automatic sckBit(output logic b);
    @(negedge clk);
    sckIn = 1'b1;
    @(negedge clk);
    b = sdo;
    sckIn = 1'b0;
  endtask

  task automatic frame(input logic [11:0] s, input bit extraConv);
    logic b;
    logic [11:0] got;
    got = '0;
    sampleIn = s;
    pulse(1'b1, 1'b0);
    sampleIn = ~s;
    check("R1 busy after strobe", int'(busy), 1);
    for (int k = 1; k <= 16; k++) begin
      if (extraConv && k == 5) pulse(1'b1, 1'b0);
      sckBit(b);
      if (k >= 3 && k <= 14) got = {got[10:0], b};
      if (k == 15 || k == 16) check("R4 sdo after data slots", int'(b), 0);
      if (k == 15) check("R2 busy before 16th edge", int'(busy), 1);
    end
    check("R3 shifted word", int'(got), int'(s));
    check("R2 busy after 16th edge", int'(busy), 0);
    idle(2);
  endtask

  initial begin
    idle(3);
    check("R10 reset busy", int'(busy), 0);
    check("R10 reset asleep", int'(asleep), 0);
    check("R10 reset sdo", int'(sdo), 0);
    rstN = 1'b1;
    idle(2);

    frame(12'hA5C, 1'b0);
    frame(12'h801, 1'b0);
    frame(12'h3F0, 1'b1);   // R2: a strobe mid-frame is ignored
    frame(12'hFFF, 1'b0);

    // R5: four strobes in a row
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0);
    idle(1);
    check("R5 asleep after four strobes", int'(asleep), 1);
    check("R5 busy cleared by sleep", int'(busy), 0);
    check("R4 sdo while asleep", int'(sdo), 0);
    // R8: strobes while asleep do nothing
    sampleIn = 12'h555;
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check("R8 still asleep", int'(asleep), 1);
    pulse(1'b0, 1'b1);
    check("R7 woken by serial clock", int'(asleep), 0);
    check("R8 no conversion after wake", int'(busy), 0);
    check("R8 sdo quiet after wake", int'(sdo), 0);
    idle(2);

    // R6: run broken by a serial clock edge
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    check("R6 no sleep with broken run", int'(asleep), 0);
    for (int i = 0; i < 16; i++) pulse(1'b0, 1'b1);
    idle(2);
    check("R6 frame closed", int'(busy), 0);

    // R9: coincident edges during a frame
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    check("R9 coincident strobe starts a new run", int'(asleep), 1);
    // R9: coincident edges while asleep
    pulse(1'b1, 1'b1);
    check("R9 woken by coincident edge", int'(asleep), 0);
    check("R9 coincident strobe rejected while asleep", int'(busy), 0);
    idle(2);
    frame(12'h0C3, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule